// File: doc/BRIEF.md
# Process Wait Timeout Scanner

This block sits beside a process scheduler and turns periodic timer ticks into wake-ups for processes whose timed waits have run out. A small divider lets only every third tick start a scan. At the start of a scan a 16-bit process tick counter advances by one. The scanner then walks a timeout vector held in a shared word memory, with one entry per process record. The walk starts at the first record after the fixed header slots and covers as many records as the header reports.

An entry fires when it is non-zero and equal to the freshly advanced tick counter. A zero entry means the process waits with no time limit. For each firing entry the scanner clears the waiting bit in that process's flags word and writes zero into the entry. It then hands the process index to the queue engine as a move onto the ready queue with no known source queue. The scanner waits on that handshake before it looks at the next index. At the end of the scan it reports whether any process was moved.

A waiter's entry is normally written by other logic as the tick count plus the requested delay, forced to at least 1, or 0 for an unlimited wait. Memory reads return data one cycle after the request.

Top module: `tmo_scanner`

## Requirements
- R1: After reset the divider is at 0, so the first tick starts a scan. A tick that starts a scan reloads the divider to 2, and every other tick decrements it. Scans therefore start on ticks 1, 4, 7 and so on, and `busy` is high in the cycle after the tick that starts a scan.
- R2: `tick_count` resets to 0 and increases by exactly one, modulo 2^16, at the start of each scan, before any entry is compared.
- R3: An entry fires only when its value is non-zero and equal to `tick_count` as advanced for that scan. Zero entries and entries with any other value are left untouched.
- R4: When an entry for index i fires, the flags word at address 4*i+1 is rewritten with bit 14 (waiting) cleared and all other bits kept.
- R5: When an entry for index i fires, the timeout word at address `tmo_base`+i is written with 0. Words of entries that do not fire are never written.
- R6: Each firing entry raises exactly one requeue request with `rq_psb` = i, in ascending index order. `rq_valid` and `rq_psb` hold steady until `rq_ready`, and the scan does not continue while the request is pending.
- R7: A scan covers indices 16 to 16+`rec_count`-1, with `rec_count` sampled when the scan starts. The entry just past the end is never examined. With `rec_count` = 0 no entry is read.
- R8: `scan_done` pulses for one cycle at the end of each scan. From then until the next scan starts, `requeued` is 1 if that scan issued at least one requeue and 0 otherwise.
- R9: Ticks that arrive during a scan still step the divider. If one of them calls for a scan, that scan runs as soon as the current one ends, with its own tick counter step.
- R10: In reset, `busy`, `rq_valid`, `mem_rd_en`, `mem_wr_en`, `scan_done` and `requeued` are 0, and `tick_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timer tick pulse |
| rec_count | input | CW | Number of process records to scan |
| tmo_base | input | AW | Word address of timeout vector element 0 |
| mem_rd_en | output | 1 | Memory read request; data returns the next cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| rq_valid | output | 1 | Requeue to ready queue requested, source unknown |
| rq_ready | input | 1 | Queue engine accepts the request |
| rq_psb | output | IW | Process index to requeue |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| requeued | output | 1 | Last scan moved at least one process |
| tick_count | output | DW | Process tick counter |

## Verification
The collision of interest is a new tick that calls for a scan while another scan is still walking the vector, possibly while it is stalled on a requeue handshake. The bench provokes this by aligning its divider model so that four ticks on consecutive cycles both start a long scan and call for a second one partway through it. The vector is loaded with entries that match either the first or the second counter value. The run passes only if the tick counter advanced by two and the requeue sequence lists the first scan's matches and then the second scan's, each in ascending order. The memory image must also equal a model that applies the two scans one after the other.

// File: rtl/tscan_pkg.sv
package tscan_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_TMO,
    S_CHK,
    S_RD_FLG,
    S_WR_FLG,
    S_WR_TMO,
    S_REQ,
    S_DONE
  } scan_state_t;
endpackage

// File: rtl/tscan_div.sv
module tscan_div #(
  parameter int RELOAD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic fire
);
  localparam int DVW = $clog2(RELOAD + 1);

  logic [DVW-1:0] div_q;

  assign fire = tick && (div_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (tick) begin
      div_q <= fire ? DVW'(RELOAD) : div_q - 1'b1;
    end
  end

  AST_FIRE_SPACED: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire); // R1
endmodule

// File: rtl/tscan_ctl.sv
module tscan_ctl
  import tscan_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 10,
  parameter int IW        = 10,
  parameter int CW        = 10,
  parameter int START_IDX = 16,
  parameter int WAIT_BIT  = 14,
  parameter int REC_SHIFT = 2,
  parameter int FLAGS_OFS = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_req,
  input  logic [CW-1:0] rec_count,
  input  logic [AW-1:0] tmo_base,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rq_valid,
  input  logic          rq_ready,
  output logic [IW-1:0] rq_psb,
  output logic          busy,
  output logic          scan_done,
  output logic          requeued,
  output logic [DW-1:0] tick_count
);
  localparam logic [DW-1:0] WAIT_MASK = DW'(1) << WAIT_BIT;

  scan_state_t   state_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] left_q;
  logic [DW-1:0] tcnt_q;
  logic          pend_q;
  logic          any_q;
  logic [AW-1:0] tmo_addr;
  logic [AW-1:0] flg_addr;
  logic          hit;
  logic          last;

  assign tmo_addr = tmo_base + AW'(idx_q);
  assign flg_addr = (AW'(idx_q) << REC_SHIFT) + AW'(FLAGS_OFS);
  assign hit      = (mem_rdata != '0) && (mem_rdata == tcnt_q);
  assign last     = (left_q == CW'(1));

  assign busy       = (state_q != S_IDLE);
  assign scan_done  = (state_q == S_DONE);
  assign rq_valid   = (state_q == S_REQ);
  assign rq_psb     = idx_q;
  assign requeued   = any_q;
  assign tick_count = tcnt_q;

  always_comb begin
    mem_rd_en = 1'b0;
    mem_wr_en = 1'b0;
    mem_addr  = tmo_addr;
    mem_wdata = '0;
    case (state_q)
      S_RD_TMO: mem_rd_en = 1'b1;
      S_RD_FLG: begin
        mem_rd_en = 1'b1;
        mem_addr  = flg_addr;
      end
      S_WR_FLG: begin
        mem_wr_en = 1'b1;
        mem_addr  = flg_addr;
        mem_wdata = mem_rdata & ~WAIT_MASK;
      end
      S_WR_TMO: mem_wr_en = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      left_q  <= '0;
      tcnt_q  <= '0;
      pend_q  <= 1'b0;
      any_q   <= 1'b0;
    end else begin
      if (start_req && state_q != S_IDLE) pend_q <= 1'b1;
      case (state_q)
        S_IDLE: begin
          if (start_req || pend_q) begin
            pend_q  <= 1'b0;
            tcnt_q  <= tcnt_q + 1'b1;
            idx_q   <= IW'(START_IDX);
            left_q  <= rec_count;
            any_q   <= 1'b0;
            state_q <= (rec_count == '0) ? S_DONE : S_RD_TMO;
          end
        end
        S_RD_TMO: state_q <= S_CHK;
        S_CHK: begin
          if (hit) begin
            state_q <= S_RD_FLG;
          end else if (last) begin
            state_q <= S_DONE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            left_q  <= left_q - 1'b1;
            state_q <= S_RD_TMO;
          end
        end
        S_RD_FLG: state_q <= S_WR_FLG;
        S_WR_FLG: state_q <= S_WR_TMO;
        S_WR_TMO: state_q <= S_REQ;
        S_REQ: begin
          if (rq_ready) begin
            any_q <= 1'b1;
            if (last) begin
              state_q <= S_DONE;
            end else begin
              idx_q   <= idx_q + 1'b1;
              left_q  <= left_q - 1'b1;
              state_q <= S_RD_TMO;
            end
          end
        end
        S_DONE: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> tick_count == $past(tick_count) + DW'(1)); // R2
  AST_WR_WAIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !mem_wdata[WAIT_BIT]); // R4
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en)); // R5
  AST_RQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_psb))); // R6
  AST_RQ_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> rq_psb >= IW'(START_IDX)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    scan_done |=> !scan_done); // R8
endmodule

// File: rtl/tmo_scanner.sv
module tmo_scanner #(
  parameter int DW        = 16,
  parameter int AW        = 10,
  parameter int IW        = 10,
  parameter int CW        = 10,
  parameter int START_IDX = 16,
  parameter int WAIT_BIT  = 14,
  parameter int REC_SHIFT = 2,
  parameter int FLAGS_OFS = 1,
  parameter int DIV_RELOAD = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [CW-1:0] rec_count,
  input  logic [AW-1:0] tmo_base,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rq_valid,
  input  logic          rq_ready,
  output logic [IW-1:0] rq_psb,
  output logic          busy,
  output logic          scan_done,
  output logic          requeued,
  output logic [DW-1:0] tick_count
);
  logic scan_fire;

  tscan_div #(.RELOAD(DIV_RELOAD)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .fire (scan_fire)
  );

  tscan_ctl #(
    .DW(DW), .AW(AW), .IW(IW), .CW(CW), .START_IDX(START_IDX),
    .WAIT_BIT(WAIT_BIT), .REC_SHIFT(REC_SHIFT), .FLAGS_OFS(FLAGS_OFS)
  ) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .start_req  (scan_fire),
    .rec_count  (rec_count),
    .tmo_base   (tmo_base),
    .mem_rd_en  (mem_rd_en),
    .mem_wr_en  (mem_wr_en),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .rq_valid   (rq_valid),
    .rq_ready   (rq_ready),
    .rq_psb     (rq_psb),
    .busy       (busy),
    .scan_done  (scan_done),
    .requeued   (requeued),
    .tick_count (tick_count)
  );

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(rq_valid || mem_rd_en || mem_wr_en)); // R10
endmodule

// File: tb/tmo_scanner_test.sv
module tmo_scanner_test;
  localparam int TB_BASE = 512;
  localparam int START   = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick;
  logic [9:0]  rec_count;
  logic [9:0]  tmo_base;
  logic        mem_rd_en, mem_wr_en;
  logic [9:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        rq_valid, rq_ready;
  logic [9:0]  rq_psb;
  logic        busy, scan_done, requeued;
  logic [15:0] tick_count;

  logic [15:0] mem     [0:1023];
  logic [15:0] ref_mem [0:1023];

  int checks = 0;
  int fails  = 0;
  int bdiv   = 0;
  logic [15:0] exp_tc = 16'd0;
  int exp_list [0:127];
  int exp_n;
  int got_list [0:255];
  int got_n;
  int done_n;

  always #5 clk = ~clk;

  tmo_scanner uut (
    .clk(clk), .rst(rst), .tick(tick), .rec_count(rec_count), .tmo_base(tmo_base),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rq_valid(rq_valid),
    .rq_ready(rq_ready), .rq_psb(rq_psb), .busy(busy), .scan_done(scan_done),
    .requeued(requeued), .tick_count(tick_count)
  );

  always @(posedge clk) begin
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit tick_model();
    if (bdiv == 0) begin
      bdiv = 2;
      return 1'b1;
    end
    bdiv--;
    return 1'b0;
  endfunction

  task automatic ref_scan(input int cnt);
    exp_tc = exp_tc + 16'd1;
    for (int i = START; i < START + cnt; i++) begin
      if (ref_mem[TB_BASE + i] != 16'd0 && ref_mem[TB_BASE + i] == exp_tc) begin
        exp_list[exp_n] = i;
        exp_n++;
        ref_mem[4 * i + 1][14] = 1'b0;
        ref_mem[TB_BASE + i] = 16'd0;
      end
    end
  endtask

  task automatic fill(input int cnt, input logic [15:0] base_tc);
    for (int i = START; i < START + cnt + 2; i++) begin
      logic [15:0] v;
      logic [15:0] f;
      case ($urandom % 4)
        0: v = 16'd0;
        1: v = base_tc + 16'd1;
        2: v = base_tc + 16'd2;
        default: v = 16'($urandom);
      endcase
      if (i == START + cnt) v = base_tc + 16'd1;
      f = 16'($urandom);
      mem[TB_BASE + i] = v;
      ref_mem[TB_BASE + i] = v;
      mem[4 * i + 1] = f;
      ref_mem[4 * i + 1] = f;
    end
  endtask

  task automatic cmp_mem(input string req);
    int mm = 0;
    int first = -1;
    for (int a = 0; a < 1024; a++) begin
      if (mem[a] !== ref_mem[a]) begin
        mm++;
        if (first < 0) first = a;
      end
    end
    chk(mm == 0, req, first, -1);
  endtask

  task automatic cmp_list(input string req);
    chk(got_n == exp_n, req, got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++)
      chk(got_list[k] == exp_list[k], req, got_list[k], exp_list[k]);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rq_ready = 1'b0;
    forever begin
      @(negedge clk);
      rq_ready = ($urandom % 3) != 0;
      if (rq_valid && rq_ready) begin
        got_list[got_n] = int'(rq_psb);
        got_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 1024; a++) begin
      mem[a] = 16'(a * 7);
      ref_mem[a] = 16'(a * 7);
    end
    rst = 1'b1;
    tick = 1'b0;
    rec_count = '0;
    tmo_base = 10'(TB_BASE);
    got_n = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!busy && !rq_valid && !mem_rd_en && !mem_wr_en && !scan_done && !requeued,
        "R10", int'({busy, rq_valid, mem_rd_en, mem_wr_en, scan_done, requeued}), 0);
    chk(tick_count == 16'd0, "R10", int'(tick_count), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int r = 0; r < 36; r++) begin
      int cnt;
      bit sc;
      logic [15:0] pre;
      cnt = (r == 3) ? 0 : (r == 0) ? 1 : int'($urandom % 40) + 1;
      rec_count = 10'(cnt);
      pre = exp_tc;
      fill(cnt, pre);
      got_n = 0;
      exp_n = 0;
      done_n = 0;
      sc = tick_model();
      if (sc) ref_scan(cnt);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      chk(busy == sc, "R1", int'(busy), int'(sc));
      if (sc) begin
        while (busy) begin
          if (scan_done) done_n++;
          @(negedge clk);
        end
        chk(tick_count == exp_tc, "R2", int'(tick_count), int'(exp_tc));
        cmp_list("R3 R6");
        chk(done_n == 1, "R8", done_n, 1);
        chk(requeued == (exp_n > 0), "R8", int'(requeued), int'(exp_n > 0));
        chk(mem[TB_BASE + START + cnt] == pre + 16'd1, "R7",
            int'(mem[TB_BASE + START + cnt]), int'(pre + 16'd1));
        cmp_mem("R4 R5");
      end else begin
        repeat (3) begin
          @(negedge clk);
          chk(!busy, "R1", int'(busy), 0);
        end
        chk(tick_count == exp_tc, "R2", int'(tick_count), int'(exp_tc));
        chk(got_n == 0, "R1", got_n, 0);
      end
    end

    // R9: ticks on consecutive cycles, second scan called during the first
    while (bdiv != 0) begin
      void'(tick_model());
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (3) @(negedge clk);
    end
    begin
      logic [15:0] pre;
      int nscan;
      pre = exp_tc;
      rec_count = 10'd40;
      fill(40, pre);
      got_n = 0;
      exp_n = 0;
      nscan = 0;
      for (int t = 0; t < 4; t++) begin
        if (tick_model()) begin
          ref_scan(40);
          nscan++;
        end
      end
      tick = 1'b1;
      repeat (4) @(negedge clk);
      tick = 1'b0;
      repeat (1500) @(negedge clk);
      chk(nscan == 2, "R9", nscan, 2);
      chk(tick_count == pre + 16'd2, "R9", int'(tick_count), int'(pre + 16'd2));
      chk(!busy, "R9", int'(busy), 0);
      cmp_list("R9");
      cmp_mem("R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule